// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte written through a one-cycle strobe lands in a holding register. The byte then moves into a shift register, and from there it leaves one bit at a time. All timing comes from a baud tick input that pulses at sixteen times the bit rate. One bit lasts a parameterised number of ticks, 16 by default.

A 7-bit configuration input sets the frame format:

- word length, from 5 to 8 bits;
- one of five parity modes;
- the stop length;
- a break control.

The format is captured when a frame starts. Two flags report progress:

- `hold_empty` shows that another byte may be written.
- `tx_empty` shows that the line has fallen silent.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever nothing is queued or shifting, `txd` is 1 (mark), `hold_empty` is 1 and `tx_empty` is 1.
- R2: A frame is a start bit at 0, the data bits least significant first, the optional parity bit, then the stop bits at 1. Start, data and parity bits each last 16 baud ticks.
- R3: `frame_cfg[1:0]` sets the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the word length are not sent and do not enter the parity.
- R4: Parity is set by `frame_cfg[5:3]`. If bit 3 is 0 there is no parity bit. The value 001 gives odd parity, 011 gives even, 101 gives a constant 1 and 111 gives a constant 0.
- R5: With odd parity, the data bits plus the parity bit hold an odd number of ones. With even parity they hold an even number.
- R6: The constant parity modes send the fixed value whatever the data.
- R7: With `frame_cfg[2]` at 0 the stop time is 16 ticks. With it at 1 the stop time is 32 ticks for 6, 7 or 8 data bits, and 24 ticks for 5 data bits.
- R8: While `frame_cfg[6]` is 1, `txd` is 0, whether the block is idle or mid-frame. Frame timing is unaffected, and releasing the break restores the normal line level.
- R9: After a write, `hold_empty` is 0. It returns to 1 in the cycle after the byte moves into the shifter, which happens while the frame is still going out.
- R10: `tx_empty` is 1 only when both the holding register and the shifter are empty.
- R11: A byte written while a frame is going out waits in the holding register. Its start bit begins on the tick right after the current stop time ends, with no idle gap, and `tx_empty` stays 0 between the two frames.
- R12: The format is captured at the start of each frame. Changing `frame_cfg[5:0]` in mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| frame_cfg | input | 7 | Frame format: [1:0] length, [2] stop, [5:3] parity, [6] break |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register is free |
| tx_empty | output | 1 | Holding register and shifter are both empty |

## Verification
The hardest state to reach is the hand-off from the holding register to the shifter on the last tick of a stop time, when a second byte is already waiting. The stimulus writes the second byte part-way through the first frame's data bits. It then checks three things: the start bit of the second frame falls on the tick that ends the first frame's stop time, `hold_empty` rises only at that point, and `tx_empty` never rises between the frames. Mid-frame changes to the format and to the break bit are made at a fixed tick offset inside a frame. This shows that the captured format holds and that break only masks the line.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int UTX_MAX_BITS = 8;

    typedef enum logic [2:0] {
        PM_NONE,
        PM_ODD,
        PM_EVEN,
        PM_ONE,
        PM_ZERO
    } par_mode_e;

    typedef enum logic [1:0] {
        SB_ONE,
        SB_ONE_HALF,
        SB_TWO
    } stop_len_e;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_START,
        TS_DATA,
        TS_PAR,
        TS_STOP
    } tx_state_e;

    typedef struct packed {
        logic [2:0] last_bit;
        par_mode_e  par;
        stop_len_e  stop;
    } frame_fmt_t;

    function automatic logic par_bit(
        input logic [UTX_MAX_BITS-1:0] d,
        input logic [2:0]              last_bit,
        input par_mode_e               mode
    );
        logic ones;
        ones = 1'b0;
        for (int i = 0; i < UTX_MAX_BITS; i++) begin
            if (i <= int'(last_bit)) begin
                ones = ones ^ d[i];
            end
        end
        case (mode)
            PM_ODD:  return ~ones;
            PM_EVEN: return ones;
            PM_ONE:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/utx_fmt_dec.sv
module utx_fmt_dec
    import utx_pkg::*;
(
    input  logic [5:0] cfg,
    output frame_fmt_t fmt
);

    always_comb begin
        fmt.last_bit = 3'd4 + {1'b0, cfg[1:0]};

        if (!cfg[3]) begin
            fmt.par = PM_NONE;
        end else if (cfg[5]) begin
            fmt.par = cfg[4] ? PM_ZERO : PM_ONE;
        end else begin
            fmt.par = cfg[4] ? PM_EVEN : PM_ODD;
        end

        if (!cfg[2]) begin
            fmt.stop = SB_ONE;
        end else if (cfg[1:0] == 2'b00) begin
            fmt.stop = SB_ONE_HALF;
        end else begin
            fmt.stop = SB_TWO;
        end
    end

endmodule

// File: rtl/utx_hold.sv
module utx_hold
    import utx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [UTX_MAX_BITS-1:0] wr_data,
    input  logic                    take,
    output logic [UTX_MAX_BITS-1:0] hold_data,
    output logic                    hold_full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_en) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // R9: the shifter only takes a byte that is actually waiting
    a_r9_take_needs_byte: assert property (@(posedge clk) disable iff (rst)
        take |-> hold_full);

    // R9: a write always leaves the holding register full
    a_r9_write_fills: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> hold_full);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    hold_full,
    input  logic [UTX_MAX_BITS-1:0] hold_data,
    input  frame_fmt_t              fmt_in,
    output logic                    take,
    output logic                    ser_out,
    output logic                    busy
);

    localparam int CNT_W = $clog2(2 * OSR);
    localparam logic [CNT_W-1:0] BIT_LAST    = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(OSR + OSR / 2 - 1);
    localparam logic [CNT_W-1:0] STOP2_LAST  = CNT_W'(2 * OSR - 1);

    tx_state_e               state;
    logic [CNT_W-1:0]        cnt;
    logic [2:0]              idx;
    logic [UTX_MAX_BITS-1:0] shreg;
    frame_fmt_t              fmt_q;
    logic                    par_q;

    logic [CNT_W-1:0] lim;
    logic             bit_done;
    logic             frame_end;

    always_comb begin
        lim = BIT_LAST;
        if (state == TS_STOP) begin
            case (fmt_q.stop)
                SB_ONE_HALF: lim = STOP15_LAST;
                SB_TWO:      lim = STOP2_LAST;
                default:     lim = BIT_LAST;
            endcase
        end
    end

    assign bit_done  = tick && (cnt == lim);
    assign frame_end = (state == TS_STOP) && bit_done;
    assign take      = hold_full && ((state == TS_IDLE) || frame_end);
    assign busy      = (state != TS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TS_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            fmt_q <= '{last_bit: 3'd7, par: PM_NONE, stop: SB_ONE};
            par_q <= 1'b0;
        end else if (take) begin
            state <= TS_START;
            cnt   <= '0;
            idx   <= '0;
            shreg <= hold_data;
            fmt_q <= fmt_in;
            par_q <= par_bit(hold_data, fmt_in.last_bit, fmt_in.par);
        end else if ((state != TS_IDLE) && tick) begin
            if (cnt == lim) begin
                cnt <= '0;
                case (state)
                    TS_START: state <= TS_DATA;
                    TS_DATA: begin
                        shreg <= shreg >> 1;
                        if (idx == fmt_q.last_bit) begin
                            state <= (fmt_q.par != PM_NONE) ? TS_PAR : TS_STOP;
                        end else begin
                            idx <= idx + 3'd1;
                        end
                    end
                    TS_PAR:  state <= TS_STOP;
                    default: state <= TS_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (state)
            TS_START: ser_out = 1'b0;
            TS_DATA:  ser_out = shreg[0];
            TS_PAR:   ser_out = par_q;
            default:  ser_out = 1'b1;
        endcase
    end

    // R2: outside the stop time no bit runs past its tick budget
    a_r2_bit_budget: assert property (@(posedge clk) disable iff (rst)
        (state != TS_STOP) |-> (cnt <= BIT_LAST));

    // R11: a waiting byte starts with a start bit right after the stop time
    a_r11_no_gap: assert property (@(posedge clk) disable iff (rst)
        (frame_end && hold_full) |=> ((state == TS_START) && !ser_out));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import utx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [6:0] frame_cfg,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    frame_fmt_t              fmt_dec;
    logic                    take;
    logic [UTX_MAX_BITS-1:0] hold_data;
    logic                    hold_full;
    logic                    ser_out;
    logic                    busy;

    utx_fmt_dec u_dec (
        .cfg (frame_cfg[5:0]),
        .fmt (fmt_dec)
    );

    utx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    utx_shifter #(.OSR(OSR)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .fmt_in    (fmt_dec),
        .take      (take),
        .ser_out   (ser_out),
        .busy      (busy)
    );

    assign txd        = frame_cfg[6] ? 1'b0 : ser_out;
    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;

    // R1: a silent transmitter holds the line at mark
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !frame_cfg[6]) |-> txd);

    // R8: break forces space
    a_r8_break_space: assert property (@(posedge clk) disable iff (rst)
        frame_cfg[6] |-> !txd);

    // R10: fully empty implies the holding register is empty
    a_r10_empty_order: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);

    // R9: the cycle after a write the holding register reports full
    a_r9_write_flag: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !hold_empty);

endmodule

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int SAMP_N     = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [6:0] cfg = 7'h03;
    logic       txd, hold_empty, tx_empty;

    int errors = 0;
    int checks = 0;
    int tick_total = 0;
    int tdiv = 0;
    logic samp [SAMP_N];
    logic he_start;
    logic he_mid;

    serial_frame_tx uut (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .frame_cfg  (cfg),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (tdiv == TICK_DIV - 1) begin
            tdiv = 0;
            baud_tick = 1'b1;
        end else begin
            tdiv = tdiv + 1;
            baud_tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (baud_tick) tick_total <= tick_total + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Write one byte; the byte becomes visible in the holding register after the edge
    task automatic put_byte(input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 hold_empty after write", int'(hold_empty), 0);
    endtask

    // Record the line once per tick from the start bit until tx_empty
    task automatic capture(input bit use_mid, input logic [6:0] mid_cfg,
                           input bit use_b, input logic [7:0] b, output int last);
        int base;
        int idx;
        bit started;
        bit sent;
        started = 0;
        sent = 0;
        base = 0;
        last = -1;
        he_start = 1'b0;
        he_mid = 1'b1;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (wr_en) wr_en = 1'b0;
            if (!started && !txd) begin
                started = 1;
                base = tick_total;
                he_start = hold_empty;
            end
            if (started) begin
                idx = tick_total - base;
                if (idx < SAMP_N) samp[idx] = txd;
                if (use_mid && idx == 20) cfg = mid_cfg;
                if (use_b && idx == 20 && !sent) begin
                    wr_data = b;
                    wr_en = 1'b1;
                    sent = 1;
                end
                if (idx == 40) he_mid = hold_empty;
                if (tx_empty) begin
                    last = idx;
                    break;
                end
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 txd idle", int'(txd), 1);
        check("R1 hold_empty", int'(hold_empty), 1);
        check("R1 tx_empty", int'(tx_empty), 1);
    endtask

    // Send one frame and check every bit, the parity and the length
    task automatic t_frame(input logic [6:0] c, input logic [7:0] d, input string tag,
                           input bit use_mid, input logic [6:0] mid_cfg);
        int n;
        int p;
        int stop;
        int total;
        int last;
        logic ones;
        logic pv;
        cfg = c;
        n = 5 + int'(c[1:0]);
        p = c[3] ? 1 : 0;
        ones = 1'b0;
        for (int i = 0; i < n; i++) ones = ones ^ d[i];
        if (!c[5]) pv = c[4] ? ones : ~ones;
        else       pv = c[4] ? 1'b0 : 1'b1;
        stop = !c[2] ? 16 : ((c[1:0] == 2'b00) ? 24 : 32);
        total = 16 * (1 + n + p) + stop;
        put_byte(d);
        capture(use_mid, mid_cfg, 1'b0, 8'h00, last);
        cfg = c;
        check({tag, " R9 hold_empty at start"}, int'(he_start), 1);
        check({tag, " R2 start bit"}, int'(samp[8]), 0);
        for (int i = 0; i < n; i++)
            check({tag, " R2 R3 data bit"}, int'(samp[16 * (i + 1) + 8]), int'(d[i]));
        if (p == 1)
            check({tag, " R4 R5 R6 parity"}, int'(samp[16 * (n + 1) + 8]), int'(pv));
        check({tag, " R2 stop level"}, int'(samp[16 * (n + 1 + p) + 8]), 1);
        check({tag, " R7 R3 frame ticks"}, last, total);
        check({tag, " R1 line idle after"}, int'(txd), 1);
    endtask

    task automatic t_break();
        int last;
        cfg = 7'h03;
        put_byte(8'hFF);
        capture(1'b1, 7'h43, 1'b0, 8'h00, last);
        check("R8 break mid-frame forces 0", int'(samp[24]), 0);
        check("R8 timing unchanged", last, 160);
        cfg = 7'h03;
        @(negedge clk);
        check("R8 release restores mark", int'(txd), 1);
        cfg = 7'h43;
        @(negedge clk);
        check("R8 idle break", int'(txd), 0);
        check("R8 R10 idle break tx_empty", int'(tx_empty), 1);
        cfg = 7'h03;
        @(negedge clk);
        check("R8 idle release", int'(txd), 1);
    endtask

    task automatic t_back_to_back();
        int last;
        logic [7:0] a;
        logic [7:0] b;
        a = 8'hC3;
        b = 8'h6D;
        cfg = 7'h03;
        put_byte(a);
        capture(1'b0, 7'h00, 1'b1, b, last);
        check("R11 R9 hold_empty low while queued", int'(he_mid), 0);
        check("R11 A stop level", int'(samp[152]), 1);
        check("R11 B start at once", int'(samp[168]), 0);
        for (int i = 0; i < 8; i++)
            check("R11 B data bit", int'(samp[160 + 16 * (i + 1) + 8]), int'(b[i]));
        check("R10 R11 no empty between frames", last, 320);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_frame(7'h03, 8'hA5, "8N1", 1'b0, 7'h00);
        t_frame(7'h08, 8'hFF, "5O1", 1'b0, 7'h00);
        t_frame(7'h1E, 8'h34, "7E2", 1'b0, 7'h00);
        t_frame(7'h04, 8'h0A, "5N1.5", 1'b0, 7'h00);
        t_frame(7'h2B, 8'h00, "8 mark parity", 1'b0, 7'h00);
        t_frame(7'h3B, 8'hFF, "8 space parity", 1'b0, 7'h00);
        t_frame(7'h05, 8'h2C, "6N2", 1'b0, 7'h00);
        t_frame(7'h03, 8'h5A, "R12 cfg change", 1'b1, 7'h00);
        t_break();
        t_back_to_back();
        summary();
        $finish;
    end

endmodule